// File: doc/BRIEF.md
# Sync-Framed Packet Header Parser

This block sits behind a serial receiver and byte de-stuffer. It takes a byte stream with a valid strobe and a separate sync indication, and recovers packets from it. A packet starts with sync. Five header bytes follow in a fixed order: sequence number, sender ID, receiver ID, payload length and header checksum. When the length is non-zero, that many payload bytes follow, and then a data checksum. The parser finds the end of each frame from the length field alone, so it uses no gap timer. The header and the payload are each validated against their own checksum.

The parser accepts a frame only when its receiver ID equals the node address or the broadcast value (all ones). For an accepted frame it forwards the payload bytes as they arrive. A sync indication at any point abandons the frame in progress and starts a new one. The consumer holds the forwarded payload until the end of the frame. It keeps the payload on a frame-good pulse and discards it on a frame-error pulse. The error pulse comes with a cause code.

Top module: `sync_frame_parser`

## Requirements
- R1: After reset all pulse outputs are low and `errCause` is 0. The parser is hunting for sync, and valid bytes that arrive before the first sync produce no output.
- R2: After a sync, valid bytes are taken in this order: sequence, sender, receiver, length, header checksum. The four header fields appear on `hdrSeq`, `hdrSrc`, `hdrDst` and `hdrLen` and hold their values while `frameGood` pulses.
- R3: The header is good when the sum modulo 256 of sequence, sender, receiver, length and the checksum byte is 0. If it is not, `frameErr` pulses with `errCause` = 1 in the cycle after the checksum byte, and the parser returns to hunting.
- R4: For a good, addressed header with length 0, `frameGood` pulses in the cycle after the header checksum byte, and no payload is expected.
- R5: For an addressed frame, each payload byte appears on `payByte` with `payValid` high for one cycle, in the cycle after that byte is accepted.
- R6: After exactly length payload bytes, the next byte is the data checksum. If the payload bytes plus the checksum sum to 0 modulo 256, `frameGood` pulses in the following cycle. If not, `frameErr` pulses with `errCause` = 2 in the following cycle.
- R7: If the receiver ID matches neither `nodeAddr` nor 0xFF, the frame produces no `payValid` and no `frameGood`. Its payload and data checksum are consumed without reporting.
- R8: A sync indication while a frame is in progress pulses `frameErr` with `errCause` = 3 in the next cycle, and a new frame begins. A sync while hunting reports nothing.
- R9: When `inSync` and `inValid` are high in the same cycle, the sync takes priority and the byte is discarded.
- R10: `frameGood` and `frameErr` are never high together, and `errCause` is non-zero exactly when `frameErr` is high.
- R11: Cycles with `inValid` low are ignored at any point in a frame, whatever their length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nodeAddr | input | DATA_W | Address of this node |
| inValid | input | 1 | Byte strobe for inByte |
| inByte | input | DATA_W | De-stuffed received byte |
| inSync | input | 1 | Sync detected in this cycle |
| payValid | output | 1 | Payload byte strobe |
| payByte | output | DATA_W | Forwarded payload byte |
| frameGood | output | 1 | Accepted frame completed |
| frameErr | output | 1 | Frame rejected |
| errCause | output | 2 | 1 header checksum, 2 data checksum, 3 sync abort |
| hdrSeq | output | DATA_W | Captured sequence number |
| hdrSrc | output | DATA_W | Captured sender ID |
| hdrDst | output | DATA_W | Captured receiver ID |
| hdrLen | output | DATA_W | Captured payload length |

## Verification
Every result is registered exactly once. The frame pulses, the cause code and the forwarded payload byte all appear in the cycle after the byte or sync that causes them. A captured header field appears in the cycle after its byte arrives. The bench drives one stimulus entry on each falling edge and checks that entry's expected outputs on the following falling edge. That is one rising edge later, which matches the single register stage. Gaps in the stream get table entries of their own with no expected output, so the one-cycle spacing holds across them.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_HDR   = 2'd1,
    CAUSE_DATA  = 2'd2,
    CAUSE_ABORT = 2'd3
  } cause_t;

  typedef enum logic [2:0] {
    ST_HUNT, ST_SEQ, ST_SRC, ST_DST, ST_LEN, ST_HCK, ST_DATA, ST_DCK
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrSum;
    logic addSum;
    logic capSeq;
    logic capSrc;
    logic capDst;
    logic capLen;
    logic loadCnt;
    logic decCnt;
    logic fwd;
  } strobe_t;

endpackage

// File: rtl/sfp_dpath.sv
module sfp_dpath
  import sfp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] nodeAddr,
  input  logic [DATA_W-1:0] inByte,
  input  strobe_t           st,
  output logic              sumZero,
  output logic              lenZero,
  output logic              cntLast,
  output logic              addrHit,
  output logic [DATA_W-1:0] payByte,
  output logic [DATA_W-1:0] hdrSeq,
  output logic [DATA_W-1:0] hdrSrc,
  output logic [DATA_W-1:0] hdrDst,
  output logic [DATA_W-1:0] hdrLen
);

  localparam logic [DATA_W-1:0] BCAST = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ONE   = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] sumNext;

  assign sumNext = sum + inByte;
  assign sumZero = (sumNext == '0);
  assign lenZero = (hdrLen == '0);
  assign cntLast = (cnt == ONE);
  assign addrHit = (hdrDst == nodeAddr) || (hdrDst == BCAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sum     <= '0;
      cnt     <= '0;
      payByte <= '0;
      hdrSeq  <= '0;
      hdrSrc  <= '0;
      hdrDst  <= '0;
      hdrLen  <= '0;
    end else begin
      if (st.clrSum)      sum <= '0;
      else if (st.addSum) sum <= sumNext;
      if (st.loadCnt)     cnt <= hdrLen;
      else if (st.decCnt) cnt <= cnt - ONE;
      if (st.fwd)    payByte <= inByte;
      if (st.capSeq) hdrSeq  <= inByte;
      if (st.capSrc) hdrSrc  <= inByte;
      if (st.capDst) hdrDst  <= inByte;
      if (st.capLen) hdrLen  <= inByte;
    end
  end

endmodule

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
  import sfp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inSync,
  input  logic    sumZero,
  input  logic    lenZero,
  input  logic    cntLast,
  input  logic    addrHit,
  output strobe_t st,
  output logic    payValid,
  output logic    frameGood,
  output logic    frameErr,
  output cause_t  errCause
);

  state_t state, nxt;
  logic   mine, mineN;
  logic   goodN, errN;
  cause_t causeN;

  always_comb begin
    nxt    = state;
    mineN  = mine;
    st     = '0;
    goodN  = 1'b0;
    errN   = 1'b0;
    causeN = CAUSE_NONE;
    if (inSync) begin
      if (state != ST_HUNT) begin
        errN   = 1'b1;
        causeN = CAUSE_ABORT;
      end
      st.clrSum = 1'b1;
      nxt       = ST_SEQ;
    end else if (inValid) begin
      case (state)
        ST_SEQ: begin st.capSeq = 1'b1; st.addSum = 1'b1; nxt = ST_SRC; end
        ST_SRC: begin st.capSrc = 1'b1; st.addSum = 1'b1; nxt = ST_DST; end
        ST_DST: begin st.capDst = 1'b1; st.addSum = 1'b1; nxt = ST_LEN; end
        ST_LEN: begin st.capLen = 1'b1; st.addSum = 1'b1; nxt = ST_HCK; end
        ST_HCK: begin
          if (!sumZero) begin
            errN   = 1'b1;
            causeN = CAUSE_HDR;
            nxt    = ST_HUNT;
          end else begin
            mineN      = addrHit;
            st.clrSum  = 1'b1;
            st.loadCnt = 1'b1;
            if (lenZero) begin
              goodN = addrHit;
              nxt   = ST_HUNT;
            end else begin
              nxt = ST_DATA;
            end
          end
        end
        ST_DATA: begin
          st.addSum = 1'b1;
          st.decCnt = 1'b1;
          st.fwd    = mine;
          if (cntLast) nxt = ST_DCK;
        end
        ST_DCK: begin
          nxt = ST_HUNT;
          if (mine) begin
            if (sumZero) begin
              goodN = 1'b1;
            end else begin
              errN   = 1'b1;
              causeN = CAUSE_DATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_HUNT;
      mine      <= 1'b0;
      payValid  <= 1'b0;
      frameGood <= 1'b0;
      frameErr  <= 1'b0;
      errCause  <= CAUSE_NONE;
    end else begin
      state     <= nxt;
      mine      <= mineN;
      payValid  <= st.fwd;
      frameGood <= goodN;
      frameErr  <= errN;
      errCause  <= causeN;
    end
  end

endmodule

// File: rtl/sync_frame_parser.sv
module sync_frame_parser
  import sfp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] nodeAddr,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inByte,
  input  logic              inSync,
  output logic              payValid,
  output logic [DATA_W-1:0] payByte,
  output logic              frameGood,
  output logic              frameErr,
  output logic [1:0]        errCause,
  output logic [DATA_W-1:0] hdrSeq,
  output logic [DATA_W-1:0] hdrSrc,
  output logic [DATA_W-1:0] hdrDst,
  output logic [DATA_W-1:0] hdrLen
);

  strobe_t st;
  logic    sumZero, lenZero, cntLast, addrHit;
  cause_t  causeQ;

  assign errCause = causeQ;

  sfp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSync(inSync),
    .sumZero(sumZero), .lenZero(lenZero), .cntLast(cntLast), .addrHit(addrHit),
    .st(st), .payValid(payValid), .frameGood(frameGood), .frameErr(frameErr),
    .errCause(causeQ)
  );

  sfp_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .nodeAddr(nodeAddr), .inByte(inByte), .st(st),
    .sumZero(sumZero), .lenZero(lenZero), .cntLast(cntLast), .addrHit(addrHit),
    .payByte(payByte), .hdrSeq(hdrSeq), .hdrSrc(hdrSrc), .hdrDst(hdrDst),
    .hdrLen(hdrLen)
  );

endmodule

// File: rtl/sfp_chk.sv
module sfp_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] nodeAddr,
  input logic              inValid,
  input logic              inSync,
  input logic              payValid,
  input logic              frameGood,
  input logic              frameErr,
  input logic [1:0]        errCause,
  input logic [DATA_W-1:0] hdrDst
);

  // R10
  good_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(frameGood && frameErr));

  // R10
  cause_with_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> (errCause != 2'd0));

  // R10
  cause_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameErr |-> (errCause == 2'd0));

  // R8
  abort_from_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && errCause == 2'd3) |-> $past(inSync));

  // R9
  no_pay_after_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    inSync |=> !payValid);

  // R5
  pay_needs_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    payValid |-> $past(inValid));

  // R7
  good_addressed_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameGood |-> (hdrDst == nodeAddr || hdrDst == {DATA_W{1'b1}}));

endmodule

bind sync_frame_parser sfp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .nodeAddr(nodeAddr), .inValid(inValid),
  .inSync(inSync), .payValid(payValid), .frameGood(frameGood),
  .frameErr(frameErr), .errCause(errCause), .hdrDst(hdrDst)
);

// File: tb/tb_sync_frame_parser.sv
module tb_sync_frame_parser;

  localparam int PERIOD = 10;
  localparam int NV     = 58;

  typedef struct packed {
    logic       sy;
    logic       vl;
    logic [7:0] b;
    logic       g;
    logic       e;
    logic [1:0] c;
    logic       p;
  } vec_t;

  // {sync, valid, byte, expGood, expErr, expCause, expPay}
  localparam vec_t VEC [NV] = '{
    '{0,1,8'hAA,0,0,0,0},                                   // R1 noise while hunting
    '{1,0,8'h00,0,0,0,0}, '{0,1,8'h01,0,0,0,0}, '{0,1,8'h02,0,0,0,0},
    '{0,1,8'h12,0,0,0,0}, '{0,1,8'h00,0,0,0,0}, '{0,1,8'hEB,1,0,0,0}, // R4
    '{1,0,8'h00,0,0,0,0}, '{0,1,8'h05,0,0,0,0}, '{0,1,8'h02,0,0,0,0},
    '{0,1,8'h12,0,0,0,0}, '{0,1,8'h02,0,0,0,0}, '{0,1,8'hE5,0,0,0,0},
    '{0,0,8'h77,0,0,0,0},                                   // R11 gap
    '{0,1,8'h10,0,0,0,1}, '{0,1,8'h20,0,0,0,1}, '{0,1,8'hD0,1,0,0,0}, // R5 R6
    '{1,0,8'h00,0,0,0,0}, '{0,1,8'h01,0,0,0,0}, '{0,1,8'h02,0,0,0,0},
    '{0,1,8'h12,0,0,0,0}, '{0,1,8'h00,0,0,0,0}, '{0,1,8'h00,0,1,1,0}, // R3
    '{1,0,8'h00,0,0,0,0}, '{0,1,8'h07,0,0,0,0}, '{0,1,8'h02,0,0,0,0},
    '{0,1,8'h12,0,0,0,0}, '{0,1,8'h01,0,0,0,0}, '{0,1,8'hE4,0,0,0,0},
    '{0,1,8'h33,0,0,0,1}, '{0,1,8'h00,0,1,2,0},             // R6 bad data
    '{1,0,8'h00,0,0,0,0}, '{0,1,8'h01,0,0,0,0}, '{0,1,8'h02,0,0,0,0},
    '{0,1,8'h34,0,0,0,0}, '{0,1,8'h01,0,0,0,0}, '{0,1,8'hC8,0,0,0,0},
    '{0,1,8'h55,0,0,0,0}, '{0,1,8'hAB,0,0,0,0},             // R7 foreign
    '{1,0,8'h00,0,0,0,0}, '{0,1,8'h09,0,0,0,0}, '{0,1,8'h03,0,0,0,0},
    '{0,1,8'hFF,0,0,0,0}, '{0,1,8'h00,0,0,0,0}, '{0,1,8'hF5,1,0,0,0}, // R7 broadcast
    '{1,0,8'h00,0,0,0,0}, '{0,1,8'h02,0,0,0,0}, '{0,1,8'h02,0,0,0,0},
    '{0,1,8'h12,0,0,0,0}, '{0,1,8'h03,0,0,0,0}, '{0,1,8'hE7,0,0,0,0},
    '{0,1,8'h44,0,0,0,1}, '{1,1,8'h99,0,1,3,0},             // R8 R9 abort
    '{0,1,8'h01,0,0,0,0}, '{0,1,8'h02,0,0,0,0}, '{0,1,8'h12,0,0,0,0},
    '{0,1,8'h00,0,0,0,0}, '{0,1,8'hEB,1,0,0,0}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] nodeAddr;
  logic       inValid;
  logic [7:0] inByte;
  logic       inSync;
  logic       payValid;
  logic [7:0] payByte;
  logic       frameGood;
  logic       frameErr;
  logic [1:0] errCause;
  logic [7:0] hdrSeq, hdrSrc, hdrDst, hdrLen;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  sync_frame_parser #(.DATA_W(8)) dut (
    .clk(clk), .rstN(rstN), .nodeAddr(nodeAddr), .inValid(inValid),
    .inByte(inByte), .inSync(inSync), .payValid(payValid), .payByte(payByte),
    .frameGood(frameGood), .frameErr(frameErr), .errCause(errCause),
    .hdrSeq(hdrSeq), .hdrSrc(hdrSrc), .hdrDst(hdrDst), .hdrLen(hdrLen)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic sy, input logic vl, input logic [7:0] b);
    inSync  = sy;
    inValid = vl;
    inByte  = b;
    @(negedge clk);
  endtask

  function automatic string tagOf(vec_t v);
    if (v.p)      return "R5";
    if (v.e)      return (v.c == 2'd1) ? "R3" : (v.c == 2'd2) ? "R6" : "R8";
    if (v.g)      return "R6";
    return "R11";
  endfunction

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; nodeAddr = 8'h12; inValid = 1'b0; inByte = '0; inSync = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {payValid, frameGood, frameErr, errCause}, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].sy, VEC[i].vl, VEC[i].b);
      check(tagOf(VEC[i]),
            {frameGood, frameErr, errCause, payValid},
            {VEC[i].g, VEC[i].e, VEC[i].c, VEC[i].p});
      if (VEC[i].p) check("R5 payByte", payByte, VEC[i].b);
    end

    // R2 header capture on a fresh frame
    drive(1, 0, 0); drive(0, 1, 8'h7E); drive(0, 1, 8'h41);
    drive(0, 0, 0); drive(0, 1, 8'h12); drive(0, 1, 8'h00);
    drive(0, 1, 8'h2F);
    check("R2 good", frameGood, 1);
    check("R2 fields", {hdrSeq, hdrSrc, hdrDst, hdrLen}, 32'h7E411200);

    // R1 reset mid-frame, then stray bytes ignored
    drive(1, 0, 0); drive(0, 1, 8'h05); drive(0, 1, 8'h02);
    rstN = 1'b0; drive(0, 0, 0); rstN = 1'b1;
    check("R1 after reset", {payValid, frameGood, frameErr, errCause}, 0);
    drive(0, 1, 8'h12); drive(0, 1, 8'h00); drive(0, 1, 8'hEB);
    check("R1 hunting ignores", {payValid, frameGood, frameErr, errCause}, 0);

    // R8 sync while hunting reports nothing
    drive(1, 0, 0);
    check("R8 sync idle", frameErr, 0);
    // R9 sync+valid: byte discarded, the frame starts on the next byte
    drive(1, 1, 8'h55);
    check("R9 resync", {frameErr, errCause}, 3'b111);
    drive(0, 1, 8'h01); drive(0, 1, 8'h02); drive(0, 1, 8'h12);
    drive(0, 1, 8'h00); drive(0, 1, 8'hEB);
    check("R9 frame after", frameGood, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule